// File: doc/BRIEF.md
# Floating-point serial audio frame receiver

This block takes the synchronous serial stream that a sound generator would normally send to a floating-point DAC and turns it into linear PCM. It has three serial inputs: a bit clock, a data line and a latch strobe. All three are passed through a two-flop synchronizer into the system clock domain. The data line is sampled on each rising edge of the bit clock, and the latch strobe marks where each channel word sits in the stream. The system clock must run at least eight times faster than the bit clock.

A frame holds two channel words, left and then right. Each word is 16 bits long and is followed by 2 padding bits. The receiver drops the padding and keeps the mantissa and exponent fields of each word. It expands every word into a signed 16-bit sample and presents the left and right samples together, with a one-cycle valid strobe once per frame. A sticky flag reports misaligned latch edges until it is cleared. A source with two serial data lines needs two instances.

Top module: `fpa_frame_rx`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `left_o`, `right_o`, `valid_o` and `err_o` are all 0.
- R2: Bits are shifted in MSB first. The first correctly framed word after reset, or after any framing error, is the left channel. Words then alternate left and right. `valid_o` is high for exactly one cycle after each right word, and never after a left word alone.
- R3: Within a 16-bit word, bits 15..13 are ignored, bits 12..3 hold the mantissa as a 10-bit two's-complement value, and bits 2..0 hold the exponent.
- R4: An exponent of 0 gives a sample of 0, whatever the mantissa is.
- R5: An exponent e from 1 to 7 gives a sample equal to mantissa × 2^(e−1), as a signed 16-bit value. The extremes are −512 at e=7, which gives −32768, and 511 at e=7, which gives 32704.
- R6: After every falling edge of `ser_lat_i`, the next 2 bit-clock rising edges are padding. Their data values have no effect. Right after reset, no padding is expected before the first word.
- R7: A framing error is raised in either of two cases: `ser_lat_i` rises when the number of word bits since the last falling edge is not 8, or `ser_lat_i` falls when that number is not 16. On a framing error, `err_o` is set, the partial word is discarded, no `valid_o` follows for that frame, and channel tracking returns to left.
- R8: `err_o` stays high until `err_clr_i` is sampled high in a cycle with no new framing error. A framing error in the same cycle as the clear leaves `err_o` high.
- R9: `left_o` and `right_o` change only in the cycle in which `valid_o` is high, and they hold their values between valid strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial bit clock, asynchronous to `clk` |
| ser_dat_i | input | 1 | Serial data, sampled on the bit clock's rising edge |
| ser_lat_i | input | 1 | Latch strobe; rises mid-word, falls at end of word |
| err_clr_i | input | 1 | Clears the sticky framing-error flag |
| left_o | output | 16 | Left channel linear sample, two's complement |
| right_o | output | 16 | Right channel linear sample, two's complement |
| valid_o | output | 1 | One-cycle strobe: a new sample pair is present |
| err_o | output | 1 | Sticky framing-error flag |

## Verification
Setting and clearing the error flag can fall in the same cycle: a bad latch edge produces the internal error event while `err_clr_i` is also high. The bench provokes this by sweeping a one-cycle clear pulse across thirteen offsets around a bad latch fall. It then checks that the flag stays set when the pulse comes at or before the event and is cleared when the pulse comes afterwards, with no reversal of that order across the sweep. The exact coincident cycle is judged by the clocked property stating that an error event is always followed by a set flag, regardless of the clear input.

// File: rtl/fpa_pkg.sv
package fpa_pkg;

  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } fpa_ch_e;

endpackage

// File: rtl/fpa_sync.sv
module fpa_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  // STAGES must be 2 or more
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= '0;
    else     stg <= {stg[STAGES-2:0], d_i};
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/fpa_deser.sv
module fpa_deser
  import fpa_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int PAD_W   = 2,
  parameter int FIELD_W = 13
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sck_i,
  input  logic               dat_i,
  input  logic               lat_i,
  output logic [FIELD_W-1:0] word_o,
  output logic               done_o,
  output fpa_ch_e            chan_o,
  output logic               err_o
);

  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam int SKP_W = $clog2(PAD_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(WORD_W / 2);
  localparam logic [CNT_W-1:0] CNT_SAT  = '1;
  localparam logic [SKP_W-1:0] SKP_LOAD = SKP_W'(PAD_W);

  logic               sck_q, lat_q;
  logic               sck_rise, lat_rise, lat_fall;
  logic [FIELD_W-1:0] sreg;
  logic [CNT_W-1:0]   cnt;
  logic [SKP_W-1:0]   skip;
  fpa_ch_e            chan;

  assign sck_rise = sck_i & ~sck_q;
  assign lat_rise = lat_i & ~lat_q;
  assign lat_fall = ~lat_i & lat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q  <= 1'b0;
      lat_q  <= 1'b0;
      sreg   <= '0;
      cnt    <= '0;
      skip   <= '0;
      chan   <= CH_LEFT;
      word_o <= '0;
      done_o <= 1'b0;
      chan_o <= CH_LEFT;
      err_o  <= 1'b0;
    end else begin
      sck_q  <= sck_i;
      lat_q  <= lat_i;
      done_o <= 1'b0;
      err_o  <= 1'b0;
      // latch edges take precedence over a bit strobe in the same cycle
      if (lat_fall) begin
        cnt  <= '0;
        skip <= SKP_LOAD;
        if (cnt == CNT_FULL) begin
          word_o <= sreg;
          done_o <= 1'b1;
          chan_o <= chan;
          chan   <= (chan == CH_LEFT) ? CH_RIGHT : CH_LEFT;
        end else begin
          err_o <= 1'b1;
          chan  <= CH_LEFT;
        end
      end else if (lat_rise) begin
        if (cnt != CNT_HALF) begin
          err_o <= 1'b1;
          cnt   <= '0;
          chan  <= CH_LEFT;
        end
      end else if (sck_rise) begin
        if (skip != '0) begin
          skip <= skip - 1'b1;
        end else begin
          sreg <= {sreg[FIELD_W-2:0], dat_i};
          if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/fpa_expand.sv
module fpa_expand #(
  parameter int MANT_W = 10,
  parameter int EXP_W  = 3,
  parameter int OUT_W  = 16
) (
  input  logic [MANT_W+EXP_W-1:0] field_i,
  output logic [OUT_W-1:0]        samp_o
);

  // mantissa x 2^(exp-1); exp 0 is silence
  function automatic logic [OUT_W-1:0] fp_to_lin(
    input logic [MANT_W-1:0] m,
    input logic [EXP_W-1:0]  e
  );
    logic [OUT_W-1:0] ext;
    ext = {{(OUT_W-MANT_W){m[MANT_W-1]}}, m};
    if (e == '0) return '0;
    return ext << (e - 1'b1);
  endfunction

  assign samp_o = fp_to_lin(field_i[EXP_W +: MANT_W], field_i[EXP_W-1:0]);

endmodule

// File: rtl/fpa_frame_rx.sv
module fpa_frame_rx
  import fpa_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int PAD_W       = 2,
  parameter int MANT_W      = 10,
  parameter int EXP_W       = 3,
  parameter int OUT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_clk_i,
  input  logic             ser_dat_i,
  input  logic             ser_lat_i,
  input  logic             err_clr_i,
  output logic [OUT_W-1:0] left_o,
  output logic [OUT_W-1:0] right_o,
  output logic             valid_o,
  output logic             err_o
);

  localparam int FIELD_W = MANT_W + EXP_W;

  logic               s_sck, s_dat, s_lat;
  logic [FIELD_W-1:0] word;
  logic               word_done;
  fpa_ch_e            word_chan;
  logic               err_evt;
  logic [OUT_W-1:0]   samp;
  logic [OUT_W-1:0]   pend_left;

  fpa_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({ser_lat_i, ser_dat_i, ser_clk_i}),
    .q_o ({s_lat, s_dat, s_sck})
  );

  fpa_deser #(.WORD_W(WORD_W), .PAD_W(PAD_W), .FIELD_W(FIELD_W)) u_deser (
    .clk    (clk),
    .rst    (rst),
    .sck_i  (s_sck),
    .dat_i  (s_dat),
    .lat_i  (s_lat),
    .word_o (word),
    .done_o (word_done),
    .chan_o (word_chan),
    .err_o  (err_evt)
  );

  fpa_expand #(.MANT_W(MANT_W), .EXP_W(EXP_W), .OUT_W(OUT_W)) u_expand (
    .field_i (word),
    .samp_o  (samp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_left <= '0;
      left_o    <= '0;
      right_o   <= '0;
      valid_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (word_done) begin
        if (word_chan == CH_LEFT) begin
          pend_left <= samp;
        end else begin
          left_o  <= pend_left;
          right_o <= samp;
          valid_o <= 1'b1;
        end
      end
    end
  end

  // a new error wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst)            err_o <= 1'b0;
    else if (err_evt)   err_o <= 1'b1;
    else if (err_clr_i) err_o <= 1'b0;
  end

endmodule

// File: rtl/fpa_rx_chk.sv
module fpa_rx_chk #(
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             valid_o,
  input logic             err_o,
  input logic             err_clr_i,
  input logic             err_evt,
  input logic             word_done,
  input logic             word_chan,
  input logic [OUT_W-1:0] left_o,
  input logic [OUT_W-1:0] right_o
);

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  a_r2_after_right: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(word_done && word_chan));

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));

  a_r7_err_sets: assert property (@(posedge clk) disable iff (rst)
    err_evt |=> err_o);

  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    (err_o && !err_clr_i) |=> err_o);

  a_r8_clears: assert property (@(posedge clk) disable iff (rst)
    (err_clr_i && !err_evt) |=> !err_o);

endmodule

bind fpa_frame_rx fpa_rx_chk #(.OUT_W(OUT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .valid_o   (valid_o),
  .err_o     (err_o),
  .err_clr_i (err_clr_i),
  .err_evt   (err_evt),
  .word_done (word_done),
  .word_chan (word_chan),
  .left_o    (left_o),
  .right_o   (right_o)
);

// File: tb/test_fpa_frame_rx.sv
module test_fpa_frame_rx;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sck = 1'b0, dat = 1'b0, lat = 1'b0, clr = 1'b0;
  logic [15:0] left_o, right_o;
  logic        valid_o, err_o;

  int n_chk = 0, n_err = 0, vcnt = 0;
  logic [15:0] cap_l = '0, cap_r = '0;

  always #4 clk = ~clk;

  fpa_frame_rx i_fpa_frame_rx (
    .clk(clk), .rst(rst), .ser_clk_i(sck), .ser_dat_i(dat), .ser_lat_i(lat),
    .err_clr_i(clr), .left_o(left_o), .right_o(right_o),
    .valid_o(valid_o), .err_o(err_o)
  );

  always @(negedge clk) if (valid_o) begin
    vcnt++;
    cap_l = left_o;
    cap_r = right_o;
  end

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  function automatic logic [15:0] mk(logic [2:0] p, int m, int e);
    return {p, 10'(m), 3'(e)};
  endfunction

  // model: sample = mantissa * 2^(e-1), zero for e = 0
  function automatic int ref_val(logic [15:0] w);
    int m, e;
    m = int'(w[12:3]);
    if (m >= 512) m -= 1024;
    e = int'(w[2:0]);
    if (e == 0) return 0;
    return m * (2 ** (e - 1));
  endfunction

  task automatic send_bit(logic b);
    @(negedge clk); dat = b; sck = 1'b0;
    repeat (6) @(negedge clk); sck = 1'b1;
    repeat (8) @(negedge clk); sck = 1'b0;
  endtask

  task automatic set_lat(logic v);
    @(negedge clk); lat = v;
    repeat (6) @(negedge clk);
  endtask

  task automatic send_raw(logic [15:0] w, int nbits, int rise_after);
    for (int k = 0; k < nbits; k++) begin
      send_bit(w[15-k]);
      if (k + 1 == rise_after) set_lat(1'b1);
    end
  endtask

  task automatic send_pad(logic pv);
    send_bit(pv); send_bit(~pv);
  endtask

  task automatic send_word(logic [15:0] w, bit lead, logic pv);
    if (lead) send_pad(pv);
    send_raw(w, 16, 8);
    set_lat(1'b0);
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic run_frame(string req, logic [15:0] l, logic [15:0] r, bit lead, logic pv);
    int v0;
    v0 = vcnt;
    send_word(l, lead, pv);
    send_word(r, 1'b1, pv);
    repeat (10) @(negedge clk);
    chk(req, "valid pulses", vcnt - v0, 1);
    chk(req, "left", int'($signed(cap_l)), ref_val(l));
    chk(req, "right", int'($signed(cap_r)), ref_val(r));
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk);
    chk("R1", "left in reset", int'(left_o), 0);
    chk("R1", "right in reset", int'(right_o), 0);
    chk("R1", "valid in reset", int'(valid_o), 0);
    chk("R1", "err in reset", int'(err_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "valid after reset", int'(valid_o), 0);
  endtask

  task automatic t_first();
    run_frame("R2", mk(3'b000, 5, 1), mk(3'b000, -3, 1), 1'b0, 1'b0);
    chk("R3", "pair first", int'($signed(cap_l)), 5);
  endtask

  task automatic t_scale();
    for (int e = 1; e <= 7; e++)
      run_frame("R5", mk(3'b101, 341, e), mk(3'b000, -512, e), 1'b1, 1'b0);
    chk("R5", "min at e7", int'($signed(cap_r)), -32768);
    run_frame("R5", mk(3'b000, 511, 7), mk(3'b000, -1, 4), 1'b1, 1'b0);
    chk("R5", "max at e7", int'($signed(cap_l)), 32704);
  endtask

  task automatic t_silence();
    run_frame("R4", mk(3'b111, -1, 0), mk(3'b000, 1, 0), 1'b1, 1'b0);
  endtask

  task automatic t_pad();
    run_frame("R6", mk(3'b111, 100, 2), mk(3'b010, -100, 3), 1'b1, 1'b1);
    run_frame("R3", mk(3'b000, 100, 2), mk(3'b000, -100, 3), 1'b1, 1'b0);
  endtask

  task automatic t_hold();
    logic [15:0] l0, r0;
    int v0;
    l0 = left_o; r0 = right_o; v0 = vcnt;
    repeat (100) @(negedge clk);
    chk("R9", "idle left", int'(left_o), int'(l0));
    chk("R9", "idle right", int'(right_o), int'(r0));
    send_word(mk(3'b000, 77, 3), 1'b1, 1'b0);
    repeat (10) @(negedge clk);
    chk("R2", "no valid after left", vcnt - v0, 0);
    chk("R9", "left held", int'(left_o), int'(l0));
    send_word(mk(3'b000, -77, 2), 1'b1, 1'b0);
    repeat (10) @(negedge clk);
    chk("R2", "valid after right", vcnt - v0, 1);
    chk("R2", "paired left", int'($signed(cap_l)), 308);
    chk("R2", "paired right", int'($signed(cap_r)), -154);
  endtask

  task automatic t_err_fall();
    int v0;
    v0 = vcnt;
    send_word(mk(3'b000, 9, 1), 1'b1, 1'b0);
    send_pad(1'b0);
    send_raw(mk(3'b000, 9, 1), 15, 8);
    set_lat(1'b0);
    repeat (10) @(negedge clk);
    chk("R7", "err on short word", int'(err_o), 1);
    chk("R7", "no valid on error", vcnt - v0, 0);
    run_frame("R7", mk(3'b000, 21, 2), mk(3'b000, -21, 2), 1'b1, 1'b0);
    chk("R8", "err sticky", int'(err_o), 1);
    pulse_clr();
    repeat (3) @(negedge clk);
    chk("R8", "err cleared", int'(err_o), 0);
  endtask

  task automatic t_err_rise();
    int v0;
    v0 = vcnt;
    send_pad(1'b0);
    send_raw(mk(3'b000, 33, 1), 7, 7);
    send_raw(16'h5555, 9, 0);
    set_lat(1'b0);
    repeat (10) @(negedge clk);
    chk("R7", "err on early rise", int'(err_o), 1);
    chk("R7", "no valid on early rise", vcnt - v0, 0);
    run_frame("R7", mk(3'b000, 40, 3), mk(3'b000, -40, 1), 1'b1, 1'b0);
    pulse_clr();
  endtask

  task automatic t_sweep();
    int res[13];
    int bad;
    for (int k = 0; k <= 12; k++) begin
      pulse_clr();
      send_pad(1'b0);
      send_raw(mk(3'b000, 3, 1), 15, 8);
      @(negedge clk); lat = 1'b0;
      repeat (k) @(negedge clk);
      clr = 1'b1;
      @(negedge clk); clr = 1'b0;
      repeat (12) @(negedge clk);
      res[k] = int'(err_o);
    end
    bad = 0;
    for (int k = 1; k <= 12; k++) if (res[k] > res[k-1]) bad++;
    chk("R8", "early clear loses to error", res[0], 1);
    chk("R8", "late clear wins", res[12], 0);
    chk("R8", "clear order monotonic", bad, 0);
    pulse_clr();
  endtask

  initial begin
    t_reset();
    t_first();
    t_scale();
    t_silence();
    t_pad();
    t_hold();
    t_err_fall();
    t_err_rise();
    t_sweep();
    repeat (5) @(negedge clk);
    summary();
  end

endmodule